// File: doc/BRIEF.md
# Ethernet Receive Frame Controller

This block is the receive control path of a 10 Mb/s Ethernet MAC. It samples serial NRZ data on a bit strobe while carrier sense is high. It searches the bit stream for the start-of-frame delimiter, then assembles octets least-significant bit first. Every octet goes into an internal 32-byte receive FIFO, and a downstream consumer drains that FIFO one octet per read.

When the sixth octet completes, the destination address is presented to an external address filter. The filter answers on `da_hit` in the same cycle. If the filter accepts the frame, the octets already stored become readable, and so do all octets that follow. If it rejects the frame, the stored octets are dropped and never become visible.

When carrier sense falls, the block issues a one-cycle status pulse. The status carries CRC, alignment, runt and collision flags, the octet count, and an abort cause. In self-receive mode the station monitors its own transmission: it still checks the CRC, but it writes nothing to the FIFO.

Top module: `eth_rx_engine`

## Requirements
- R1: While `crs` is high and no frame is open, bits are shifted in on `rx_bit_en`. A frame opens only when the last eight bits, in arrival order, are 1,0,1,0,1,0,1,1. Carrier that rises and falls without this pattern produces no status pulse and writes nothing to the FIFO.
- R2: After the delimiter, bits are assembled into octets with the first bit as bit 0. Each complete octet of an accepted frame, from destination address through FCS, is readable in arrival order on `fifo_dout`. `fifo_rd` pops the oldest octet while `fifo_empty` is low.
- R3: When the sixth octet completes, `da_valid` pulses for one cycle, and `da_addr` holds the six address octets, with the first octet in bits 7:0. `da_hit` is sampled in that cycle. A miss drops every octet of the frame, so that none is ever readable, and sets cause 2 (mismatch).
- R4: The frame closes on the first cycle `crs` is low. `st_valid` pulses for one cycle in the next cycle, and `st_octets` gives the number of complete octets. `st_cause` uses these codes: 0 none, 1 overrun, 2 mismatch, 3 no resources, 4 collision, 5 error reject.
- R5: `st_crc` is set when the CRC-32 register has not reached 0xC704DD7B at the last octet boundary. The register uses polynomial 0x04C11DB7, starts at all ones, and runs over the octets from destination address through FCS.
- R6: `st_align` is set when the received bit count is not a multiple of eight and the CRC is also bad. Trailing bits after a good CRC set neither flag.
- R7: `st_runt` is set when fewer than 64 octets are received.
- R8: A `col` pulse during a frame sets `st_col`. With `rej_col` high it also sets cause 4, and no further octets are written.
- R9: With `rej_err` high and no earlier cause, a CRC, alignment or runt error reports cause 5. With `rej_err` low such frames report cause 0.
- R10: If `buf_ready` is low when the delimiter is seen (outside self-receive), the block reports cause 3, issues no `da_valid` and writes no octet.
- R11: An octet that completes while the FIFO holds 32 octets sets cause 1, and no later octet of that frame is written. The 32 octets already held stay readable.
- R12: If `tx_busy` is high when the delimiter is seen, the block sets `st_self`, issues no `da_valid` and writes nothing. The CRC check and the octet count still operate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit_en | input | 1 | One-cycle strobe marking a valid receive bit |
| rxd | input | 1 | Serial NRZ receive data |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision indication |
| tx_busy | input | 1 | Station is transmitting (self-receive) |
| buf_ready | input | 1 | Memory resources available |
| rej_col | input | 1 | Abort frames that see a collision |
| rej_err | input | 1 | Reject frames with CRC, alignment or runt error |
| da_hit | input | 1 | Address filter verdict, valid with da_valid |
| fifo_rd | input | 1 | Pop one octet |
| fifo_dout | output | 8 | Oldest readable octet |
| fifo_empty | output | 1 | No readable octet |
| da_valid | output | 1 | Destination address ready for filtering |
| da_addr | output | 48 | Destination address, first octet in bits 7:0 |
| st_valid | output | 1 | End-of-frame status strobe |
| st_align | output | 1 | Alignment error |
| st_crc | output | 1 | CRC error |
| st_runt | output | 1 | Fewer than 64 octets |
| st_col | output | 1 | Collision seen |
| st_self | output | 1 | Frame was self-received |
| st_cause | output | 3 | Abort cause code |
| st_octets | output | 16 | Complete octets received |

## Verification
A bit phase that drifts from the delimiter shows up within one octet: the FIFO returns rotated data, and `da_addr` fails to match the filter. A CRC register that is seeded or stepped wrongly shows up only at the status pulse, one cycle after carrier falls, as a spurious or missing CRC flag on a frame the bench built with a known FCS. A commit pointer that is wrong shows up as octets from a rejected frame becoming readable, or as a fill count after an overrun other than 32. The directed frames cover good data, address misses, runts, trailing bits, collisions, lack of resources, overrun and self-receive.

// File: rtl/eth_rx_engine.sv
module eth_rx_engine #(
  parameter int FIFO_DEPTH = 32,
  parameter int MIN_OCTETS = 64,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit_en,
  input  logic             rxd,
  input  logic             crs,
  input  logic             col,
  input  logic             tx_busy,
  input  logic             buf_ready,
  input  logic             rej_col,
  input  logic             rej_err,
  input  logic             da_hit,
  input  logic             fifo_rd,
  output logic [7:0]       fifo_dout,
  output logic             fifo_empty,
  output logic             da_valid,
  output logic [47:0]      da_addr,
  output logic             st_valid,
  output logic             st_align,
  output logic             st_crc,
  output logic             st_runt,
  output logic             st_col,
  output logic             st_self,
  output logic [2:0]       st_cause,
  output logic [LEN_W-1:0] st_octets
);
  localparam int          AW      = $clog2(FIFO_DEPTH);
  localparam logic [7:0]  DELIM   = 8'b10101011;
  localparam logic [31:0] POLY    = 32'h04C11DB7;
  localparam logic [31:0] RESIDUE = 32'hC704DD7B;
  localparam logic [2:0]  C_NONE = 3'd0, C_OVR = 3'd1, C_MIS = 3'd2,
                          C_RES  = 3'd3, C_COL = 3'd4, C_ERR = 3'd5;

  logic [7:0]       mem [FIFO_DEPTH];
  logic [AW:0]      wr_ptr, rd_ptr, base_ptr;
  logic             in_frame, mon, accepted, col_seen;
  logic [7:0]       hunt_sh, oct_sh;
  logic [2:0]       bit_ph;
  logic [LEN_W-1:0] oct_cnt;
  logic [31:0]      crc, crc_oct;
  logic [2:0]       cause;

  wire [7:0]  hunt_nx   = {hunt_sh[6:0], rxd};
  wire [7:0]  oct_nx    = {rxd, oct_sh[7:1]};
  wire        fb        = crc[31] ^ rxd;
  wire [31:0] crc_nx    = {crc[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
  wire        oct_done  = in_frame && crs && rx_bit_en && (bit_ph == 3'd7);
  wire [AW:0] fill      = wr_ptr - rd_ptr;
  wire        full      = (fill == (AW+1)'(FIFO_DEPTH));
  wire        can_write = !mon && (cause == C_NONE);
  wire        push      = oct_done && can_write && !full;
  wire [AW:0] vis_ptr   = accepted ? wr_ptr : base_ptr;
  wire        crc_bad   = (crc_oct != RESIDUE);
  wire        short_f   = (oct_cnt < LEN_W'(MIN_OCTETS));
  wire        misalign  = (bit_ph != 3'd0) && crc_bad;
  wire        err_any   = crc_bad || short_f || misalign;

  assign fifo_empty = (rd_ptr == vis_ptr);
  assign fifo_dout  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk)
    if (push) mem[wr_ptr[AW-1:0]] <= oct_nx;

  always_ff @(posedge clk)
    if (!rst_n) rd_ptr <= '0;
    else if (fifo_rd && !fifo_empty) rd_ptr <= rd_ptr + (AW+1)'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; base_ptr <= '0;
      in_frame <= 1'b0; mon <= 1'b0; accepted <= 1'b0; col_seen <= 1'b0;
      hunt_sh <= '0; oct_sh <= '0; bit_ph <= '0; oct_cnt <= '0;
      crc <= '1; crc_oct <= '1; cause <= C_NONE;
      da_valid <= 1'b0; da_addr <= '0;
      st_valid <= 1'b0; st_align <= 1'b0; st_crc <= 1'b0; st_runt <= 1'b0;
      st_col <= 1'b0; st_self <= 1'b0; st_cause <= C_NONE; st_octets <= '0;
    end else begin
      da_valid <= 1'b0;
      st_valid <= 1'b0;
      if (!in_frame) begin
        if (!crs) hunt_sh <= '0;
        else if (rx_bit_en) begin
          hunt_sh <= hunt_nx;
          if (hunt_nx == DELIM) begin
            in_frame <= 1'b1;
            mon      <= tx_busy;
            accepted <= 1'b0;
            col_seen <= 1'b0;
            cause    <= (tx_busy || buf_ready) ? C_NONE : C_RES;
            crc      <= '1;
            crc_oct  <= '1;
            bit_ph   <= '0;
            oct_cnt  <= '0;
          end
        end
      end else if (!crs) begin
        in_frame  <= 1'b0;
        hunt_sh   <= '0;
        st_valid  <= 1'b1;
        st_crc    <= crc_bad;
        st_align  <= misalign;
        st_runt   <= short_f;
        st_col    <= col_seen;
        st_self   <= mon;
        st_octets <= oct_cnt;
        st_cause  <= (cause == C_NONE && rej_err && err_any) ? C_ERR : cause;
        if (accepted) base_ptr <= wr_ptr;
        else          wr_ptr   <= base_ptr;
      end else begin
        if (da_valid && cause == C_NONE) begin
          if (da_hit) accepted <= 1'b1;
          else        cause    <= C_MIS;
        end
        if (col) begin
          col_seen <= 1'b1;
          if (rej_col && cause == C_NONE) cause <= C_COL;
        end
        if (rx_bit_en) begin
          crc    <= crc_nx;
          bit_ph <= bit_ph + 3'd1;
          oct_sh <= oct_nx;
          if (bit_ph == 3'd7) begin
            crc_oct <= crc_nx;
            if (oct_cnt != '1) oct_cnt <= oct_cnt + LEN_W'(1);
            if (oct_cnt < LEN_W'(6)) da_addr <= {oct_nx, da_addr[47:8]};
            if (oct_cnt == LEN_W'(5) && can_write) da_valid <= 1'b1;
            if (can_write) begin
              if (full) cause  <= C_OVR;
              else      wr_ptr <= wr_ptr + (AW+1)'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/eth_rx_engine_sva.sv
module eth_rx_engine_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       da_valid,
  input logic       st_valid,
  input logic       st_align,
  input logic       st_crc,
  input logic       st_col,
  input logic       st_self,
  input logic [2:0] st_cause
);
  AST_STATUS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid); // R4
  AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> !da_valid); // R3
  AST_ALIGN_IMPLIES_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_align) |-> st_crc); // R6
  AST_COL_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_cause == 3'd4) |-> st_col); // R8
  AST_SELF_NO_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_self) |-> (st_cause != 3'd2 && st_cause != 3'd1)); // R12
  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_cause <= 3'd5)); // R4
endmodule

bind eth_rx_engine eth_rx_engine_sva u_sva (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .st_valid(st_valid),
  .st_align(st_align), .st_crc(st_crc), .st_col(st_col),
  .st_self(st_self), .st_cause(st_cause)
);

// File: tb/eth_rx_engine_test.sv
module eth_rx_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_bit_en = 1'b0, rxd = 1'b0, crs = 1'b0, col = 1'b0;
  logic tx_busy = 1'b0, buf_ready = 1'b1, rej_col = 1'b0, rej_err = 1'b0;
  logic da_hit, fifo_rd;
  logic [7:0] fifo_dout;
  logic fifo_empty, da_valid, st_valid, st_align, st_crc, st_runt, st_col, st_self;
  logic [47:0] da_addr;
  logic [2:0] st_cause;
  logic [15:0] st_octets;

  localparam logic [47:0] STA = 48'h5F4E3D2C1B0A;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  always #4 clk = ~clk;

  logic drain_en = 1'b1;
  assign da_hit  = (da_addr == STA);
  assign fifo_rd = drain_en && !fifo_empty;

  eth_rx_engine uut (.*);

  int checks = 0, failures = 0;
  logic [7:0] frm [0:127];
  logic [7:0] got [0:127];
  int rx_n = 0, da_cnt = 0;
  logic got_st = 1'b0;
  logic c_align, c_crc, c_runt, c_col, c_self;
  logic [2:0] c_cause;
  logic [15:0] c_oct;

  always @(negedge clk) begin
    if (fifo_rd) begin
      if (rx_n < 128) got[rx_n] = fifo_dout;
      rx_n++;
    end
    if (da_valid) da_cnt++;
    if (st_valid) begin
      got_st = 1'b1; c_align = st_align; c_crc = st_crc; c_runt = st_runt;
      c_col = st_col; c_self = st_self; c_cause = st_cause; c_oct = st_octets;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build(int n, bit match);
    for (int i = 0; i < n; i++)
      frm[i] = (i < 6) ? (match ? STA[8*i +: 8] : 8'hA0 + 8'(i)) : 8'(i * 7 + 3);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); rxd = b; rx_bit_en = 1'b1;
    @(negedge clk); rx_bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int k = 0; k < 8; k++) send_bit(v[k]);
  endtask

  task automatic run_frame(int n, bit bad_fcs, int extra, int col_at);
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        c = {c[30:0], 1'b0} ^ ((c[31] ^ frm[i][k]) ? POLY : 32'h0);
    for (int j = 0; j < 4; j++)
      for (int k = 0; k < 8; k++) frm[n+j][k] = ~c[31 - (8*j + k)];
    if (bad_fcs) frm[n] = frm[n] ^ 8'h01;
    got_st = 1'b0; rx_n = 0; da_cnt = 0;
    @(negedge clk); crs = 1'b1;
    repeat (7) send_byte(8'h55);
    send_byte(8'hD5);
    for (int i = 0; i < n + 4; i++) begin
      if (i == col_at) begin
        @(negedge clk); col = 1'b1;
        @(negedge clk); col = 1'b0;
      end
      send_byte(frm[i]);
    end
    for (int e = 0; e < extra; e++) send_bit(e[0]);
    @(negedge clk); crs = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic cmp_bytes(string tag, int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (got[i] !== frm[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic t_reset;
    chk("R2 reset fifo_empty", fifo_empty, 1);
    chk("R4 reset st_valid", st_valid, 0);
    chk("R3 reset da_valid", da_valid, 0);
  endtask

  task automatic t_good;
    build(60, 1); run_frame(60, 0, 0, -1);
    chk("R4 status seen", got_st, 1);
    chk("R4 octets", c_oct, 64);
    chk("R5 crc ok", c_crc, 0);
    chk("R7 not runt", c_runt, 0);
    chk("R6 no align", c_align, 0);
    chk("R4 cause none", c_cause, 0);
    chk("R2 byte count", rx_n, 64);
    cmp_bytes("R2 byte data", 64);
    chk("R3 one da_valid", da_cnt, 1);
  endtask

  task automatic t_mismatch;
    build(60, 0); run_frame(60, 0, 0, -1);
    chk("R3 mismatch cause", c_cause, 2);
    chk("R3 mismatch no data", rx_n, 0);
    chk("R3 mismatch fifo empty", fifo_empty, 1);
  endtask

  task automatic t_runt;
    build(36, 1); run_frame(36, 0, 0, -1);
    chk("R7 runt flag", c_runt, 1);
    chk("R7 runt octets", c_oct, 40);
    chk("R9 runt no reject", c_cause, 0);
    chk("R7 runt crc ok", c_crc, 0);
    chk("R2 runt data", rx_n, 40);
  endtask

  task automatic t_badcrc;
    build(60, 1); run_frame(60, 1, 0, -1);
    chk("R5 crc error", c_crc, 1);
    chk("R6 aligned", c_align, 0);
    chk("R9 no reject when off", c_cause, 0);
  endtask

  task automatic t_dribble;
    build(60, 1); run_frame(60, 0, 3, -1);
    chk("R6 dribble good crc", c_crc, 0);
    chk("R6 dribble no align", c_align, 0);
    chk("R4 dribble octets", c_oct, 64);
    build(60, 1); run_frame(60, 1, 3, -1);
    chk("R6 dribble bad align", c_align, 1);
    chk("R5 dribble bad crc", c_crc, 1);
  endtask

  task automatic t_rejerr;
    rej_err = 1'b1;
    build(60, 1); run_frame(60, 1, 0, -1);
    chk("R9 error reject cause", c_cause, 5);
    build(60, 1); run_frame(60, 0, 0, -1);
    chk("R9 good frame not rejected", c_cause, 0);
    rej_err = 1'b0;
  endtask

  task automatic t_nores;
    buf_ready = 1'b0;
    build(60, 1); run_frame(60, 0, 0, -1);
    chk("R10 cause no resources", c_cause, 3);
    chk("R10 no data", rx_n, 0);
    chk("R10 no da_valid", da_cnt, 0);
    buf_ready = 1'b1;
  endtask

  task automatic t_overrun;
    drain_en = 1'b0;
    build(60, 1); run_frame(60, 0, 0, -1);
    chk("R11 cause overrun", c_cause, 1);
    drain_en = 1'b1;
    repeat (80) @(negedge clk);
    chk("R11 held octets", rx_n, 32);
    cmp_bytes("R11 held data", 32);
  endtask

  task automatic t_col;
    build(60, 1); run_frame(60, 0, 0, 20);
    chk("R8 col flag", c_col, 1);
    chk("R8 col no abort", c_cause, 0);
    chk("R8 col data kept", rx_n, 64);
    rej_col = 1'b1;
    build(60, 1); run_frame(60, 0, 0, 20);
    chk("R8 col abort cause", c_cause, 4);
    chk("R8 col writes stop", rx_n, 20);
    rej_col = 1'b0;
  endtask

  task automatic t_self;
    tx_busy = 1'b1;
    build(60, 1); run_frame(60, 0, 0, -1);
    chk("R12 self flag", c_self, 1);
    chk("R12 self no data", rx_n, 0);
    chk("R12 self no da_valid", da_cnt, 0);
    chk("R12 self crc checked", c_crc, 0);
    chk("R12 self octets", c_oct, 64);
    tx_busy = 1'b0;
    build(60, 1); run_frame(60, 1, 0, -1);
    chk("R12 normal frame not self", c_self, 0);
  endtask

  task automatic t_nosfd;
    got_st = 1'b0; rx_n = 0;
    @(negedge clk); crs = 1'b1;
    repeat (6) send_byte(8'h55);
    @(negedge clk); crs = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 no status without delimiter", got_st, 0);
    chk("R1 no data without delimiter", rx_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_good;
    t_mismatch;
    t_runt;
    t_badcrc;
    t_dribble;
    t_rejerr;
    t_nores;
    t_overrun;
    t_col;
    t_self;
    t_nosfd;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule